// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. Each request carries a 4-bit condition code and a snapshot of the four condition flags: negative, zero, overflow and carry. In bit-test mode it also carries a data byte and a mask. One cycle later the block returns a single take decision. Target address arithmetic, program counter update and offset fetch are left to the surrounding pipeline.

The flag conditions are arranged in complementary pairs. Bits [3:1] of the code pick a base predicate and bit 0 inverts it. Unsigned relations are built from carry and zero. Signed relations are built from negative, overflow and zero. In bit-test mode the flags play no part: the decision comes only from the data byte and the mask. The flags are returned unchanged next to the decision, so a later stage sees exactly what was tested.

Top module: `branch_cond_unit`

## Requirements
- R1: A request accepted with `valid_i`=1 at a rising edge produces `valid_o`=1 and its result on `take_o` and `flags_o` after that edge. While `valid_o`=0, `take_o` is 0. During reset, `valid_o`, `take_o` and `flags_o` are all 0.
- R2: With `bit_mode_i`=0, code 0x0 is always taken and code 0x1 is never taken, whatever the flags.
- R3: With `bit_mode_i`=0, codes 2k and 2k+1 give opposite decisions for the same flags, for every k from 0 to 7.
- R4: Unsigned relations, where `flags_i` is {N,Z,V,C} with N in bit 3 and C in bit 0: code 0x2 (higher) is ~C&~Z, 0x3 (lower or same) is C|Z, 0x4 (higher or same) is ~C, 0x5 (lower) is C.
- R5: Code 0x6 (not equal) is ~Z and code 0x7 (equal) is Z.
- R6: Code 0x8 (no overflow) is ~V and code 0x9 (overflow) is V.
- R7: Code 0xA (plus) is taken when N=0 and code 0xB (minus) is taken when N=1.
- R8: Signed relations: 0xC (greater or equal) is ~(N^V), 0xD (less) is N^V, 0xE (greater) is ~Z&~(N^V), 0xF (less or equal) is Z|(N^V).
- R9: With `bit_mode_i`=1 and `cond_i[0]`=1, the branch is taken exactly when (`mem_i` & `mask_i`) is zero. Flags and `cond_i[3:1]` have no effect.
- R10: With `bit_mode_i`=1 and `cond_i[0]`=0, the branch is taken exactly when every masked bit of `mem_i` is 1, that is (~`mem_i` & `mask_i`) is zero. An all-zero mask is therefore taken. Flags and `cond_i[3:1]` have no effect.
- R11: `flags_o` equals the `flags_i` of the accepted request for every code and mode. The block never alters a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| cond_i | input | 4 | Condition code |
| bit_mode_i | input | 1 | Select bit-test evaluation |
| flags_i | input | 4 | Flags {N,Z,V,C} |
| mem_i | input | DATA_W | Data byte for bit tests |
| mask_i | input | DATA_W | Bit-test mask |
| valid_o | output | 1 | Result present |
| take_o | output | 1 | Branch taken |
| flags_o | output | 4 | Flags passed through unchanged |

## Verification
The bench sweeps all sixteen codes against all sixteen flag combinations. This exposes a signed relation built from carry instead of N^V, and a greater-than that ignores zero so that equal operands are taken. It then cross-checks every complementary pair, which catches a code whose inverting bit is dropped. Bit tests use all-zero and all-one masks, a single bit just missing, and random flags and high code bits. A design that uses `mem_i` where it should use its complement, or that lets the flags leak into bit-test mode, would fail these cases. Idle cycles catch a stale `take_o` left high after a taken branch.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned BASE_N = 1 << (COND_W - 1);

  typedef enum logic [COND_W-2:0] {
    BASE_ALW = 3'd0,
    BASE_HI  = 3'd1,
    BASE_HS  = 3'd2,
    BASE_NE  = 3'd3,
    BASE_VC  = 3'd4,
    BASE_PL  = 3'd5,
    BASE_GE  = 3'd6,
    BASE_GT  = 3'd7
  } base_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/bcu_flag_eval.sv
module bcu_flag_eval
  import bcu_pkg::*;
(
  input  flags_t            flags_i,
  output logic [BASE_N-1:0] base_o
);
  logic sgn_lt;

  always_comb begin
    sgn_lt           = flags_i.n ^ flags_i.v;
    base_o           = '0;
    base_o[BASE_ALW] = 1'b1;
    base_o[BASE_HI]  = ~flags_i.c & ~flags_i.z;
    base_o[BASE_HS]  = ~flags_i.c;
    base_o[BASE_NE]  = ~flags_i.z;
    base_o[BASE_VC]  = ~flags_i.v;
    base_o[BASE_PL]  = ~flags_i.n;
    base_o[BASE_GE]  = ~sgn_lt;
    base_o[BASE_GT]  = ~flags_i.z & ~sgn_lt;
  end
endmodule

// File: rtl/bcu_bit_eval.sv
module bcu_bit_eval #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              all_set_o,
  output logic              all_clr_o
);
  logic [DATA_W-1:0] miss_set;
  logic [DATA_W-1:0] miss_clr;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign miss_set[i] = mask_i[i] & ~mem_i[i];
    assign miss_clr[i] = mask_i[i] &  mem_i[i];
  end

  assign all_set_o = ~|miss_set;
  assign all_clr_o = ~|miss_clr;
endmodule

// File: rtl/bcu_select.sv
module bcu_select
  import bcu_pkg::*;
(
  input  logic [BASE_N-1:0] base_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              bit_mode_i,
  input  logic              all_set_i,
  input  logic              all_clr_i,
  output logic              take_o
);
  logic flag_take;
  logic bit_take;

  // bit 0 of the code inverts the base predicate
  assign flag_take = base_i[cond_i[COND_W-1:1]] ^ cond_i[0];
  assign bit_take  = cond_i[0] ? all_clr_i : all_set_i;
  assign take_o    = bit_mode_i ? bit_take : flag_take;
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        cond_i,
  input  logic              bit_mode_i,
  input  logic [3:0]        flags_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              valid_o,
  output logic              take_o,
  output logic [3:0]        flags_o
);
  logic [BASE_N-1:0] base;
  logic              all_set;
  logic              all_clr;
  logic              take_d;

  bcu_flag_eval u_flag (
    .flags_i (flags_t'(flags_i)),
    .base_o  (base)
  );

  bcu_bit_eval #(.DATA_W(DATA_W)) u_bit (
    .mem_i     (mem_i),
    .mask_i    (mask_i),
    .all_set_o (all_set),
    .all_clr_o (all_clr)
  );

  bcu_select u_sel (
    .base_i     (base),
    .cond_i     (cond_i),
    .bit_mode_i (bit_mode_i),
    .all_set_i  (all_set),
    .all_clr_i  (all_clr),
    .take_o     (take_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      take_o  <= 1'b0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      take_o  <= valid_i & take_d;
      if (valid_i) flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        cond_i,
  input logic              bit_mode_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] mem_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              valid_o,
  input logic              take_o,
  input logic [3:0]        flags_o
);
  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !take_o); // R1
  AST_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bit_mode_i && cond_i == 4'h0) |=> take_o); // R2
  AST_NEVER_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bit_mode_i && cond_i == 4'h1) |=> !take_o); // R2
  AST_CARRY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bit_mode_i && cond_i == 4'h5) |=> take_o == $past(flags_i[0])); // R4
  AST_BIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_mode_i && cond_i[0] && (mem_i & mask_i) == '0) |=> take_o); // R9
  AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_mode_i && mask_i == '0) |=> take_o); // R10
  AST_FLAGS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o == $past(flags_i)); // R11
endmodule

bind branch_cond_unit bcu_checker #(.DATA_W(DATA_W)) u_bcu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .cond_i     (cond_i),
  .bit_mode_i (bit_mode_i),
  .flags_i    (flags_i),
  .mem_i      (mem_i),
  .mask_i     (mask_i),
  .valid_o    (valid_o),
  .take_o     (take_o),
  .flags_o    (flags_o)
);

// File: tb/branch_cond_unit_bench.sv
`timescale 1ns/1ps
module branch_cond_unit_bench;
  localparam int unsigned DATA_W = 8;

  typedef struct {
    logic       take;
    logic [3:0] flags;
    string      req;
    int         tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic [3:0]        cond_i = '0;
  logic              bit_mode_i = 1'b0;
  logic [3:0]        flags_i = '0;
  logic [DATA_W-1:0] mem_i = '0;
  logic [DATA_W-1:0] mask_i = '0;
  logic              valid_o;
  logic              take_o;
  logic [3:0]        flags_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sb_q[$];
  logic seen[16][16];

  always #2.5 clk = ~clk;

  branch_cond_unit #(.DATA_W(DATA_W)) u_branch_cond_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .valid_i    (valid_i),
    .cond_i     (cond_i),
    .bit_mode_i (bit_mode_i),
    .flags_i    (flags_i),
    .mem_i      (mem_i),
    .mask_i     (mask_i),
    .valid_o    (valid_o),
    .take_o     (take_o),
    .flags_o    (flags_o)
  );

  function automatic string req_of(logic bm, logic [3:0] c);
    if (bm) return c[0] ? "R9" : "R10";
    case (c[3:1])
      3'd0: return "R2";
      3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic model(logic bm, logic [3:0] c, logic [3:0] f,
                                 logic [DATA_W-1:0] m, logic [DATA_W-1:0] k);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    if (bm) return c[0] ? ((m & k) == '0) : ((~m & k) == '0);
    case (c)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return !cy && !z;
      4'h3: return cy || z;
      4'h4: return !cy;
      4'h5: return cy;
      4'h6: return !z;
      4'h7: return z;
      4'h8: return !v;
      4'h9: return v;
      4'hA: return !n;
      4'hB: return n;
      4'hC: return n == v;
      4'hD: return n != v;
      4'hE: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic send(logic bm, logic [3:0] c, logic [3:0] f,
                      logic [DATA_W-1:0] m, logic [DATA_W-1:0] k, int tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; bit_mode_i = bm; cond_i = c; flags_i = f; mem_i = m; mask_i = k;
    e.take = model(bm, c, f, m, k);
    e.flags = f;
    e.req = req_of(bm, c);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    cond_i = 4'h0;
  endtask

  // monitor: pops one expected item for each result the design presents
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 valid_o=1 with empty scoreboard, expected no result");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (take_o !== e.take) begin
          errors++;
          $display("FAIL %s tag=%0d take_o actual=%b expected=%b", e.req, e.tag, take_o, e.take);
        end
        checks++;
        if (flags_o !== e.flags) begin
          errors++;
          $display("FAIL R11 tag=%0d flags_o actual=%h expected=%h", e.tag, flags_o, e.flags);
        end
        if (e.tag >= 0 && e.tag < 256) seen[e.tag / 16][e.tag % 16] = take_o;
      end
    end else if (rst_n) begin
      checks++;
      if (take_o !== 1'b0) begin
        errors++;
        $display("FAIL R1 idle take_o actual=%b expected=0", take_o);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if ({valid_o, take_o, flags_o} !== 6'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b expected=000000", {valid_o, take_o, flags_o});
    end
    rst_n = 1'b1;
    idle();

    // R2 R4 R5 R6 R7 R8 R11: every code against every flag combination
    for (int f = 0; f < 16; f++)
      for (int c = 0; c < 16; c++)
        send(1'b0, 4'(c), 4'(f), 8'hA5, 8'h3C, f * 16 + c);
    idle();
    idle();

    // R3: complementary pairs
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 8; k++) begin
        checks++;
        if (seen[f][2*k] === seen[f][2*k+1]) begin
          errors++;
          $display("FAIL R3 flags=%h pair=%0d actual=%b/%b expected opposite",
                   f, k, seen[f][2*k], seen[f][2*k+1]);
        end
      end

    // R9 branch on clear bits
    send(1'b1, 4'h1, 4'hF, 8'hF0, 8'h0F, 300);
    send(1'b1, 4'h1, 4'h0, 8'hF0, 8'h10, 301);
    send(1'b1, 4'hF, 4'h5, 8'h00, 8'hFF, 302);
    send(1'b1, 4'h7, 4'hA, 8'h01, 8'hFF, 303);
    // R10 branch on set bits, including empty and full masks
    send(1'b1, 4'h0, 4'h0, 8'hF0, 8'hF0, 310);
    send(1'b1, 4'h0, 4'hF, 8'hF0, 8'hF8, 311);
    send(1'b1, 4'hE, 4'h3, 8'h00, 8'h00, 312);
    send(1'b1, 4'h6, 4'hC, 8'hFF, 8'hFF, 313);
    send(1'b1, 4'h2, 4'h9, 8'h7F, 8'hFF, 314);
    idle();
    // R1: taken result followed by idle cycles must leave take_o low
    send(1'b0, 4'h0, 4'h0, 8'h00, 8'h00, 320);
    idle();
    idle();
    // R9 R10: random data, flags and high code bits
    for (int i = 0; i < 200; i++)
      send(1'b1, 4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom & $urandom), 400 + i);
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1 results missing actual=%0d pending expected=0", sb_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule